// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the memory address for a load or store and, where the indexing mode calls for it, the new value for the base register. It takes a 32-bit base value and one of three offset sources: an immediate constant, an index register value, or an index register value shifted left by 0 to 3 places. The offset is either added to or subtracted from the base.

Three indexing modes control what happens to the result. In offset mode the sum goes to memory and the base is left alone. In pre-indexed mode the sum goes to memory and is also written back to the base. In post-indexed mode the base itself goes to memory and the sum is written back. All arithmetic wraps modulo 2^32 and never raises a fault.

The datapath is combinational. The parameter `REG_OUT` adds one output register stage, and it is on by default. The register file, the memory access and alignment checks belong to neighbouring blocks.

Top module: `lsu_addr_gen`

## Requirements
- R1: With mode_i = 2'b00 (offset), ea_o = base ± offset, wb_en_o = 0 and wb_data_o = base_i.
- R2: With mode_i = 2'b01 (pre-indexed), ea_o = base ± offset, wb_data_o equals ea_o and wb_en_o = 1.
- R3: With mode_i = 2'b10 (post-indexed), ea_o = base_i, wb_data_o = base ± offset and wb_en_o = 1.
- R4: With off_sel_i = 2'b00 the offset is imm_i.
- R5: With off_sel_i = 2'b01 the offset is index_i unshifted, and shamt_i has no effect.
- R6: With off_sel_i = 2'b10 the offset is index_i logically shifted left by shamt_i (0 to 3), and bits shifted past bit 31 are lost.
- R7: sub_i = 0 adds the offset to the base and sub_i = 1 subtracts it.
- R8: Sums and differences wrap modulo 2^32 with no other effect.
- R9: mode_i = 2'b11 behaves exactly as offset mode (no writeback), and off_sel_i = 2'b11 selects a zero offset.
- R10: With REG_OUT = 1, every output reflects the inputs present at the previous rising clock edge, and an active-low reset clears ea_o, wb_data_o and wb_en_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Base register value |
| imm_i | input | 32 | Immediate offset |
| index_i | input | 32 | Index register value |
| shamt_i | input | 2 | Left shift amount for the shifted-index offset |
| off_sel_i | input | 2 | Offset source: 00 immediate, 01 index, 10 shifted index, 11 zero |
| sub_i | input | 1 | 1 subtracts the offset, 0 adds it |
| mode_i | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 offset |
| ea_o | output | 32 | Effective address |
| wb_data_o | output | 32 | Value to write back to the base register |
| wb_en_o | output | 1 | Base writeback enable |

## Verification
With the default output register, ea_o, wb_data_o and wb_en_o all become valid one cycle after their inputs: the first rising edge captures the inputs and the outputs hold the result until the next edge. The bench changes inputs only on falling edges. It checks the outputs on the falling edge that follows the capturing rising edge, so every sample falls halfway through the cycle in which the result is due. The bound checker compares the registered outputs with the inputs one edge earlier. It enables these comparisons only after the first capture out of reset.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;
  typedef enum logic [1:0] {
    SRC_IMM   = 2'b00,
    SRC_IDX   = 2'b01,
    SRC_IDXSH = 2'b10,
    SRC_ZERO  = 2'b11
  } off_src_e;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'b00,
    IDX_PRE    = 2'b01,
    IDX_POST   = 2'b10,
    IDX_RSVD   = 2'b11
  } idx_mode_e;
endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 2
) (
  input  logic [DATA_W-1:0]  imm_i,
  input  logic [DATA_W-1:0]  index_i,
  input  logic [SHIFT_W-1:0] shamt_i,
  input  logic [1:0]         off_sel_i,
  output logic [DATA_W-1:0]  off_o
);
  import lsu_agu_pkg::*;

  always_comb begin
    unique case (off_src_e'(off_sel_i))
      SRC_IMM:   off_o = imm_i;
      SRC_IDX:   off_o = index_i;
      SRC_IDXSH: off_o = index_i << shamt_i;
      default:   off_o = '0;
    endcase
  end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] off_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o
);
  // two's complement subtract via inverted operand and carry-in
  logic [DATA_W-1:0] opnd;
  assign opnd  = sub_i ? ~off_i : off_i;
  assign sum_o = base_i + opnd + {{(DATA_W-1){1'b0}}, sub_i};
endmodule

// File: rtl/agu_mode_mux.sv
module agu_mode_mux #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] ea_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              wb_en_o
);
  import lsu_agu_pkg::*;

  always_comb begin
    unique case (idx_mode_e'(mode_i))
      IDX_PRE: begin
        ea_o      = sum_i;
        wb_data_o = sum_i;
        wb_en_o   = 1'b1;
      end
      IDX_POST: begin
        ea_o      = base_i;
        wb_data_o = sum_i;
        wb_en_o   = 1'b1;
      end
      default: begin
        ea_o      = sum_i;
        wb_data_o = base_i;
        wb_en_o   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] ea_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              wb_en_i,
  output logic [DATA_W-1:0] ea_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              wb_en_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ea_o      <= '0;
        wb_data_o <= '0;
        wb_en_o   <= 1'b0;
      end else begin
        ea_o      <= ea_i;
        wb_data_o <= wb_data_i;
        wb_en_o   <= wb_en_i;
      end
    end
  end else begin : g_comb
    assign ea_o      = ea_i;
    assign wb_data_o = wb_data_i;
    assign wb_en_o   = wb_en_i;
  end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 2,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  base_i,
  input  logic [DATA_W-1:0]  imm_i,
  input  logic [DATA_W-1:0]  index_i,
  input  logic [SHIFT_W-1:0] shamt_i,
  input  logic [1:0]         off_sel_i,
  input  logic               sub_i,
  input  logic [1:0]         mode_i,
  output logic [DATA_W-1:0]  ea_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic               wb_en_o
);
  logic [DATA_W-1:0] off, sum, ea_c, wb_c;
  logic              wb_en_c;

  agu_offset_sel #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_off (
    .imm_i(imm_i), .index_i(index_i), .shamt_i(shamt_i),
    .off_sel_i(off_sel_i), .off_o(off)
  );

  agu_addsub #(.DATA_W(DATA_W)) u_add (
    .base_i(base_i), .off_i(off), .sub_i(sub_i), .sum_o(sum)
  );

  agu_mode_mux #(.DATA_W(DATA_W)) u_mode (
    .base_i(base_i), .sum_i(sum), .mode_i(mode_i),
    .ea_o(ea_c), .wb_data_o(wb_c), .wb_en_o(wb_en_c)
  );

  agu_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ea_i(ea_c), .wb_data_i(wb_c), .wb_en_i(wb_en_c),
    .ea_o(ea_o), .wb_data_o(wb_data_o), .wb_en_o(wb_en_o)
  );
endmodule

// File: rtl/lsu_addr_gen_chk.sv
module lsu_addr_gen_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 2,
  parameter bit          REG_OUT = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DATA_W-1:0]  base_i,
  input logic [DATA_W-1:0]  imm_i,
  input logic [DATA_W-1:0]  index_i,
  input logic [SHIFT_W-1:0] shamt_i,
  input logic [1:0]         off_sel_i,
  input logic               sub_i,
  input logic [1:0]         mode_i,
  input logic [DATA_W-1:0]  ea_o,
  input logic [DATA_W-1:0]  wb_data_o,
  input logic               wb_en_o
);
  if (REG_OUT) begin : g_seq
    // set once outputs hold a capture taken out of reset
    logic past_ok;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) past_ok <= 1'b0;
      else         past_ok <= 1'b1;
    end

    p_offset_no_wb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(mode_i) == 2'b00 |-> !wb_en_o && wb_data_o == $past(base_i));
    p_pre_same_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(mode_i) == 2'b01 |-> wb_en_o && ea_o == wb_data_o);
    p_post_base_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(mode_i) == 2'b10 |-> wb_en_o && ea_o == $past(base_i));
    p_imm_add_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(mode_i) == 2'b00 && $past(off_sel_i) == 2'b00 && !$past(sub_i)
      |-> ea_o == $past(base_i) + $past(imm_i));
    p_shift_add_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(mode_i) == 2'b00 && $past(off_sel_i) == 2'b10 && !$past(sub_i)
      |-> ea_o == $past(base_i) + ($past(index_i) << $past(shamt_i)));
    p_rsvd_no_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(mode_i) == 2'b11 |-> !wb_en_o);
  end else begin : g_comb
    p_offset_no_wb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i == 2'b00 |-> !wb_en_o && wb_data_o == base_i);
    p_pre_same_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i == 2'b01 |-> wb_en_o && ea_o == wb_data_o);
    p_post_base_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i == 2'b10 |-> wb_en_o && ea_o == base_i);
    p_imm_add_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i == 2'b00 && off_sel_i == 2'b00 && !sub_i |-> ea_o == base_i + imm_i);
    p_shift_add_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i == 2'b00 && off_sel_i == 2'b10 && !sub_i
      |-> ea_o == base_i + (index_i << shamt_i));
    p_rsvd_no_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i == 2'b11 |-> !wb_en_o);
  end
endmodule

bind lsu_addr_gen lsu_addr_gen_chk #(
  .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_i), .imm_i(imm_i),
  .index_i(index_i), .shamt_i(shamt_i), .off_sel_i(off_sel_i), .sub_i(sub_i),
  .mode_i(mode_i), .ea_o(ea_o), .wb_data_o(wb_data_o), .wb_en_o(wb_en_o)
);

// File: tb/tb_lsu_addr_gen.sv
`timescale 1ns/1ps
module tb_lsu_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] base_i = '0, imm_i = '0, index_i = '0;
  logic [1:0]  shamt_i = '0, off_sel_i = '0, mode_i = '0;
  logic        sub_i = 1'b0;
  logic [31:0] ea_o, wb_data_o;
  logic        wb_en_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  lsu_addr_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_i), .imm_i(imm_i),
    .index_i(index_i), .shamt_i(shamt_i), .off_sel_i(off_sel_i), .sub_i(sub_i),
    .mode_i(mode_i), .ea_o(ea_o), .wb_data_o(wb_data_o), .wb_en_o(wb_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at falling edge, result captured at rising edge, sample at next falling edge
  task automatic apply(input logic [1:0] md, input logic [1:0] src, input logic sb,
                       input logic [31:0] b, input logic [31:0] im,
                       input logic [31:0] ix, input logic [1:0] sh);
    @(negedge clk_i);
    mode_i = md; off_sel_i = src; sub_i = sb;
    base_i = b; imm_i = im; index_i = ix; shamt_i = sh;
    @(negedge clk_i);
  endtask

  task automatic expect_out(input string req, input logic [31:0] ea,
                            input logic [31:0] wb, input logic en);
    chk({req, " ea"}, ea_o, ea);
    chk({req, " wb_data"}, wb_data_o, wb);
    chk({req, " wb_en"}, {31'd0, wb_en_o}, {31'd0, en});
  endtask

  task automatic t_reset_r10();
    rst_ni = 1'b0;
    base_i = 32'h1234_5678; imm_i = 32'h10; mode_i = 2'b01;
    @(negedge clk_i);
    expect_out("R10 reset", 32'h0, 32'h0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_offset_r1();
    apply(2'b00, 2'b00, 1'b0, 32'h0000_1000, 32'h24, 32'h0, 2'd0);
    expect_out("R1 offset add", 32'h0000_1024, 32'h0000_1000, 1'b0);
    apply(2'b00, 2'b00, 1'b1, 32'h0000_1000, 32'h24, 32'h0, 2'd0);
    expect_out("R1/R7 offset sub", 32'h0000_0FDC, 32'h0000_1000, 1'b0);
  endtask

  task automatic t_pre_r2();
    apply(2'b01, 2'b01, 1'b0, 32'h2000_0000, 32'h0, 32'h0000_0040, 2'd0);
    expect_out("R2/R5 pre add", 32'h2000_0040, 32'h2000_0040, 1'b1);
    apply(2'b01, 2'b00, 1'b1, 32'h2000_0000, 32'h8, 32'h0, 2'd0);
    expect_out("R2/R7 pre sub", 32'h1FFF_FFF8, 32'h1FFF_FFF8, 1'b1);
  endtask

  task automatic t_post_r3();
    apply(2'b10, 2'b00, 1'b0, 32'h0000_0100, 32'h1, 32'h0, 2'd0);
    expect_out("R3 post add", 32'h0000_0100, 32'h0000_0101, 1'b1);
    apply(2'b10, 2'b10, 1'b1, 32'h0000_0100, 32'h0, 32'h4, 2'd2);
    expect_out("R3/R6 post sub shifted", 32'h0000_0100, 32'h0000_00F0, 1'b1);
  endtask

  task automatic t_sources_r4_r5();
    // R4: immediate chosen even with a distinct index present
    apply(2'b00, 2'b00, 1'b0, 32'h0000_0000, 32'h0000_0077, 32'h0000_5500, 2'd3);
    expect_out("R4 imm source", 32'h0000_0077, 32'h0, 1'b0);
    // R5: unshifted index ignores shamt_i
    apply(2'b00, 2'b01, 1'b0, 32'h0000_0000, 32'h0000_0077, 32'h0000_5500, 2'd3);
    expect_out("R5 index source", 32'h0000_5500, 32'h0, 1'b0);
  endtask

  task automatic t_shift_r6();
    for (int s = 0; s < 4; s++) begin
      apply(2'b00, 2'b10, 1'b0, 32'h0000_1000, 32'h0, 32'h0000_0003, s[1:0]);
      expect_out("R6 shift", 32'h0000_1000 + (32'h3 << s), 32'h0000_1000, 1'b0);
    end
    apply(2'b00, 2'b10, 1'b0, 32'h0, 32'h0, 32'hF000_0001, 2'd3);
    expect_out("R6 shift drop", 32'h8000_0008, 32'h0, 1'b0);
  endtask

  task automatic t_wrap_r8();
    apply(2'b01, 2'b00, 1'b0, 32'hFFFF_FFFF, 32'h1, 32'h0, 2'd0);
    expect_out("R8 add wrap", 32'h0, 32'h0, 1'b1);
    apply(2'b10, 2'b00, 1'b1, 32'h0, 32'h4, 32'h0, 2'd0);
    expect_out("R8 sub wrap", 32'h0, 32'hFFFF_FFFC, 1'b1);
  endtask

  task automatic t_reserved_r9();
    apply(2'b11, 2'b01, 1'b0, 32'h0000_0300, 32'h0, 32'h0000_0030, 2'd0);
    expect_out("R9 mode 11", 32'h0000_0330, 32'h0000_0300, 1'b0);
    apply(2'b01, 2'b11, 1'b1, 32'h0000_0300, 32'h55, 32'h66, 2'd1);
    expect_out("R9 zero offset", 32'h0000_0300, 32'h0000_0300, 1'b1);
  endtask

  task automatic t_latency_r10();
    // outputs hold the previous capture until the next rising edge
    apply(2'b01, 2'b00, 1'b0, 32'h0000_0A00, 32'h0A, 32'h0, 2'd0);
    mode_i = 2'b10; base_i = 32'h0000_0B00; imm_i = 32'h0B;
    #1;
    expect_out("R10 hold", 32'h0000_0A0A, 32'h0000_0A0A, 1'b1);
    @(negedge clk_i);
    expect_out("R10 next", 32'h0000_0B00, 32'h0000_0B0B, 1'b1);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    t_reset_r10();
    t_offset_r1();
    t_pre_r2();
    t_post_r3();
    t_sources_r4_r5();
    t_shift_r6();
    t_wrap_r8();
    t_reserved_r9();
    t_latency_r10();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule